// File: doc/BRIEF.md
# Delayed Transmit Scheduler

This block turns a received-packet arrival time into the time at which a reply must start. It runs a free-running 40-bit timestamp counter that is never cleared during operation and wraps modulo 2^40. A receive strobe copies the counter into a capture register. When a reply is requested, the block adds the reply delay to the captured time and clears the low nine bits of the sum, which puts the result on a 512-tick grid. It then adds an antenna-path offset and wraps the result to 40 bits. This gives the transmit time.

At the request the block checks whether that time is still ahead of the counter. The check uses modular arithmetic. If the time is still ahead, the block waits and fires a one-cycle start strobe when the counter equals it. If not, the block aborts and raises a too-late flag.

The controller has two states. `ST_IDLE` accepts a request. The transition ARM_OK moves to `ST_WAIT` when the time is ahead. The transition ARM_LATE stays in `ST_IDLE` and sets the late flag. `ST_WAIT` returns to `ST_IDLE` through FIRE, in the cycle the counter matches, and that transition sets the done flag. A counter load port exists so that tests can place the counter near its wrap point.

Top module: `txsched_top`

## Requirements
- R1: After reset the counter `sys_time` reads 0. It then advances by one every cycle and wraps from 2^40-1 to 0. Asserting `cnt_load` makes `sys_time` equal `cnt_load_val` in the next cycle.
- R2: A cycle with `rx_evt` high copies the `sys_time` value of that cycle into `rx_time`, which shows it from the next cycle on.
- R3: An accepted request latches `tx_time` = ((((`rx_time` + `reply_dly`) mod 2^40) with bits 8..0 cleared) + zero-extended `ant_dly`) mod 2^40. The value is visible in the cycle after the request.
- R4: A request is late when d = (`tx_time` − `sys_time`) mod 2^40, taken in the request cycle, is zero or has bit 39 set. A late request sets `late` in the next cycle and keeps `busy` low. No strobe follows it.
- R5: A request that is not late sets `busy`. `tx_start` is then high for exactly one cycle, the one in which `sys_time` equals `tx_time`, and `busy` drops after it.
- R6: `done` rises in the cycle after the strobe and holds until the next accepted request. An accepted request clears `done` and loads `late`. `late` and `done` are never high together.
- R7: A receive strobe while `busy` is high updates `rx_time` only. `tx_time` and the strobe cycle stay unchanged.
- R8: A request while `busy` is high is ignored. `tx_time`, `late` and the strobe cycle stay unchanged.
- R9: A synchronous active-low reset clears the counter, the capture register, `tx_time`, `busy`, `late`, `done` and `tx_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_load | input | 1 | Load the counter with `cnt_load_val` (test use) |
| cnt_load_val | input | 40 | Counter load value |
| rx_evt | input | 1 | Receive event strobe |
| reply_dly | input | 40 | Reply delay in ticks |
| ant_dly | input | 16 | Antenna-path offset in ticks |
| arm | input | 1 | Schedule request |
| sys_time | output | 40 | Current counter value |
| rx_time | output | 40 | Captured arrival time |
| tx_time | output | 40 | Latched transmit time |
| tx_start | output | 1 | One-cycle transmit start strobe |
| busy | output | 1 | A transmission is pending |
| late | output | 1 | Last accepted request was too late |
| done | output | 1 | Last accepted request has fired |

## Verification
The assertions assume that the counter is not loaded while a transmission is pending. A load at that point could jump past the scheduled time, and the strobe would then never fire. The stimulus therefore uses `cnt_load` only when `busy` is low. It also keeps `ant_dly` and the reply delay small enough that every accepted schedule fires within a few thousand cycles. Loads are placed to produce the equal-time late case, the one-tick-ahead case and a sum that overflows 40 bits. Receive strobes and extra requests are driven only between an accepted request and its strobe.

// File: rtl/txsched_pkg.sv
package txsched_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } sched_state_t;

endpackage

// File: rtl/txsched_counter.sv
module txsched_counter #(
    parameter int TS_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    input  logic            rx_evt,
    output logic [TS_W-1:0] now,
    output logic [TS_W-1:0] rx_ts
);

    localparam logic [TS_W-1:0] ONE = {{(TS_W-1){1'b0}}, 1'b1};

    // Free-running timestamp, wraps naturally at 2^TS_W
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now <= '0;
        end else if (load) begin
            now <= load_val;
        end else begin
            now <= now + ONE;
        end
    end

    // Arrival capture, independent of any pending schedule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_ts <= '0;
        end else if (rx_evt) begin
            rx_ts <= now;
        end
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> (rx_ts == $past(now)));

endmodule

// File: rtl/txsched_calc.sv
module txsched_calc #(
    parameter int TS_W     = 40,
    parameter int GRID_LSB = 9,
    parameter int ANT_W    = 16
) (
    input  logic [TS_W-1:0]  rx_ts,
    input  logic [TS_W-1:0]  dly,
    input  logic [ANT_W-1:0] ant,
    input  logic [TS_W-1:0]  now,
    output logic [TS_W-1:0]  tx_calc,
    output logic             is_late
);

    localparam logic [TS_W-1:0] GRID_MASK =
        {{(TS_W-GRID_LSB){1'b1}}, {GRID_LSB{1'b0}}};

    logic [TS_W-1:0] raw_sum;
    logic [TS_W-1:0] coarse;
    logic [TS_W-1:0] ant_ext;
    logic [TS_W-1:0] ahead;

    always_comb begin
        raw_sum = rx_ts + dly;
        coarse  = raw_sum & GRID_MASK;
        ant_ext = {{(TS_W-ANT_W){1'b0}}, ant};
        tx_calc = coarse + ant_ext;
        // distance to the target, modular; zero or negative means missed
        ahead   = tx_calc - now;
        is_late = ahead[TS_W-1] || (ahead == '0);
    end

endmodule

// File: rtl/txsched_fsm.sv
module txsched_fsm
    import txsched_pkg::*;
#(
    parameter int TS_W = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [TS_W-1:0] now,
    input  logic [TS_W-1:0] tx_calc,
    input  logic            is_late,
    output logic [TS_W-1:0] tx_time,
    output logic            tx_start,
    output logic            busy,
    output logic            late,
    output logic            done
);

    sched_state_t state_q;
    sched_state_t state_d;
    logic         accept;
    logic         hit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm && !is_late) begin
                    state_d = ST_WAIT;      // ARM_OK
                end                         // ARM_LATE stays idle
            end
            ST_WAIT: begin
                if (hit) begin
                    state_d = ST_IDLE;      // FIRE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hit      = (now == tx_time);
        accept   = (state_q == ST_IDLE) && arm;
        busy     = (state_q == ST_WAIT);
        tx_start = busy && hit;
    end

    // Schedule and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_time <= '0;
            late    <= 1'b0;
            done    <= 1'b0;
        end else if (accept) begin
            tx_time <= tx_calc;
            late    <= is_late;
            done    <= 1'b0;
        end else if (tx_start) begin
            done    <= 1'b1;
        end
    end

    // R4
    late_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late) |-> !busy);

    // R5
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (!tx_start && done && !busy));

    // R6
    late_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(late && done));

    // R8
    arm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arm) |=> ($stable(tx_time) && !late));

endmodule

// File: rtl/txsched_top.sv
module txsched_top #(
    parameter int TS_W     = 40,
    parameter int GRID_LSB = 9,
    parameter int ANT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_load,
    input  logic [TS_W-1:0]  cnt_load_val,
    input  logic             rx_evt,
    input  logic [TS_W-1:0]  reply_dly,
    input  logic [ANT_W-1:0] ant_dly,
    input  logic             arm,
    output logic [TS_W-1:0]  sys_time,
    output logic [TS_W-1:0]  rx_time,
    output logic [TS_W-1:0]  tx_time,
    output logic             tx_start,
    output logic             busy,
    output logic             late,
    output logic             done
);

    logic [TS_W-1:0] tx_calc;
    logic            is_late;

    txsched_counter #(.TS_W(TS_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .rx_evt   (rx_evt),
        .now      (sys_time),
        .rx_ts    (rx_time)
    );

    txsched_calc #(.TS_W(TS_W), .GRID_LSB(GRID_LSB), .ANT_W(ANT_W)) u_calc (
        .rx_ts   (rx_time),
        .dly     (reply_dly),
        .ant     (ant_dly),
        .now     (sys_time),
        .tx_calc (tx_calc),
        .is_late (is_late)
    );

    txsched_fsm #(.TS_W(TS_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .now      (sys_time),
        .tx_calc  (tx_calc),
        .is_late  (is_late),
        .tx_time  (tx_time),
        .tx_start (tx_start),
        .busy     (busy),
        .late     (late),
        .done     (done)
    );

    // R7
    rx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_evt && !tx_start) |=> ($stable(tx_time) && busy));

endmodule

// File: tb/txsched_top_bench.sv
module txsched_top_bench;

    localparam logic [39:0] MASK = 40'hFF_FFFF_FE00;
    localparam logic [39:0] TOP  = 40'hFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_load = 1'b0;
    logic [39:0] cnt_load_val = '0;
    logic        rx_evt = 1'b0;
    logic [39:0] reply_dly = '0;
    logic [15:0] ant_dly = '0;
    logic        arm = 1'b0;
    logic [39:0] sys_time, rx_time, tx_time;
    logic        tx_start, busy, late, done;

    int checks = 0;
    int errors = 0;
    logic [39:0] exp_rx = '0;
    logic [39:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    txsched_top u_txsched_top (
        .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .rx_evt(rx_evt), .reply_dly(reply_dly), .ant_dly(ant_dly), .arm(arm),
        .sys_time(sys_time), .rx_time(rx_time), .tx_time(tx_time),
        .tx_start(tx_start), .busy(busy), .late(late), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Monitor: pop the expected strobe time when the strobe appears (R5)
    always @(negedge clk) begin
        if (rst_n && tx_start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected strobe", sys_time, '0);
            end else begin
                logic [39:0] e;
                e = exp_q.pop_front();
                chk(sys_time == e, "R5 strobe time", sys_time, e);
                chk(tx_time == e, "R5 tx_time at strobe", tx_time, e);
            end
        end
    end

    task automatic load_cnt(input logic [39:0] v);
        cnt_load = 1'b1; cnt_load_val = v;
        tick();
        cnt_load = 1'b0;
        chk(sys_time == v, "R1 load", sys_time, v);
    endtask

    task automatic pulse_rx();
        exp_rx = sys_time;
        rx_evt = 1'b1;
        tick();
        rx_evt = 1'b0;
        chk(rx_time == exp_rx, "R2 capture", rx_time, exp_rx);
    endtask

    task automatic arm_req(input logic [39:0] dly, input logic [15:0] ant,
                           output logic [39:0] exp_tx, output bit exp_late);
        logic [39:0] d;
        reply_dly = dly; ant_dly = ant;
        exp_tx = ((exp_rx + dly) & MASK) + {24'd0, ant};
        d = exp_tx - sys_time;
        exp_late = d[39] || (d == '0);
        if (!exp_late) exp_q.push_back(exp_tx);
        arm = 1'b1;
        tick();
        arm = 1'b0;
        chk(tx_time == exp_tx, "R3 tx_time", tx_time, exp_tx);
        chk(late == exp_late, "R4 late flag", {39'd0, late}, {39'd0, exp_late});
        chk(done == 1'b0, "R6 done cleared by arm", {39'd0, done}, 40'd0);
        if (exp_late)
            chk(busy == 1'b0, "R4 no pending after late", {39'd0, busy}, 40'd0);
    endtask

    task automatic wait_fire();
        int n = 0;
        while (exp_q.size() != 0 && n < 6000) begin
            tick();
            n++;
        end
        chk(exp_q.size() == 0, "R5 strobe arrived", 40'(exp_q.size()), 40'd0);
        tick();
        chk(done == 1'b1, "R6 done after strobe", {39'd0, done}, 40'd1);
        chk(late == 1'b0, "R6 late low with done", {39'd0, late}, 40'd0);
        chk(busy == 1'b0, "R5 busy drops", {39'd0, busy}, 40'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 40'd0, 40'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [39:0] etx, keep, a;
        bit el;

        // R9 reset state
        repeat (3) tick();
        chk(sys_time == '0, "R9 counter reset", sys_time, '0);
        chk(rx_time == '0, "R9 capture reset", rx_time, '0);
        chk({tx_start, busy, late, done} == 4'b0, "R9 flags reset",
            {36'd0, tx_start, busy, late, done}, '0);
        rst_n = 1'b1;
        tick();
        a = sys_time;
        tick();
        chk(sys_time == a + 40'd1, "R1 increment", sys_time, a + 40'd1);

        // Normal schedule with grid truncation (R3, R5)
        repeat (37) tick();
        pulse_rx();
        arm_req(40'd1500, 16'd37, etx, el);
        chk(etx[8:0] == 9'd37, "R3 grid low bits", {31'd0, etx[8:0]}, 40'd37);
        chk(el == 1'b0, "R4 expected ahead", {39'd0, el}, 40'd0);
        wait_fire();

        // done holds until next arm (R6)
        repeat (5) tick();
        chk(done == 1'b1, "R6 done holds", {39'd0, done}, 40'd1);

        // Equal time is late (R4)
        pulse_rx();
        etx = ((exp_rx + 40'd700) & MASK) + 40'd5;
        load_cnt(etx);
        arm_req(40'd700, 16'd5, etx, el);
        chk(late == 1'b1, "R4 equal time late", {39'd0, late}, 40'd1);
        chk(done == 1'b0, "R6 exclusive", {39'd0, done}, 40'd0);

        // One tick ahead fires immediately (R5)
        load_cnt(etx - 40'd1);
        arm_req(40'd700, 16'd5, etx, el);
        wait_fire();

        // Receive and arm while pending (R7, R8)
        pulse_rx();
        arm_req(40'd2000, 16'd3, etx, el);
        keep = etx;
        repeat (10) tick();
        pulse_rx();
        chk(tx_time == keep, "R7 tx_time kept on rx", tx_time, keep);
        chk(busy == 1'b1, "R7 still pending", {39'd0, busy}, 40'd1);
        reply_dly = 40'd10; ant_dly = 16'd0;
        arm = 1'b1;
        tick();
        arm = 1'b0;
        chk(tx_time == keep, "R8 tx_time kept on arm", tx_time, keep);
        chk(late == 1'b0, "R8 late unchanged", {39'd0, late}, 40'd0);
        wait_fire();

        // Overflow past 2^40 (R3, R1 wrap)
        load_cnt(TOP - 40'd299);
        pulse_rx();
        arm_req(40'd250, 16'd600, etx, el);
        chk(tx_time == 40'd88, "R3 wrapped tx_time", tx_time, 40'd88);
        wait_fire();

        // Far in the past after wrap (R4)
        arm_req(40'd0, 16'd0, etx, el);
        chk(late == 1'b1, "R4 past time late", {39'd0, late}, 40'd1);
        repeat (600) tick();
        chk(exp_q.size() == 0 && done == 1'b0, "R4 no strobe after late",
            {39'd0, done}, 40'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule